// File: doc/BRIEF.md
# Multi-Page-Size Address Translation Buffer

This block is a small, fully associative translation cache that turns 32-bit virtual addresses into physical addresses. Each of its entries maps one of three region sizes: a 1 MB section, a 64 KB large page or a 4 KB small page. The size of an entry sets how many upper address bits it compares. The lower bits pass straight from the virtual address to the physical address. As a result, one entry can cover a whole large region.

The lookup side is purely combinational. A virtual address, a user/privileged flag and a read/write flag go in. In the same cycle the block returns:
- a miss flag,
- a hit flag,
- a permission fault,
- the physical address,
- the cacheable and bufferable attributes of the matching region.

A miss is meant to start an external table walker. That walker later writes the resolved mapping through the refill port. A synchronous flush input drops every mapping at once.

Top module: `xlat_tlb`

## Requirements
- R1: With size code 00 (section), an entry matches when virtual bits [31:20] equal its tag. The physical address is then the entry's base bits [31:20] followed by virtual bits [19:0].
- R2: With size code 01 (large page), an entry compares virtual bits [31:16]. Physical bits [15:0] come from the virtual address.
- R3: With size code 10 (small page), an entry compares virtual bits [31:12]. Physical bits [11:0] come from the virtual address.
- R4: On a hit, `lk_cacheable` and `lk_bufferable` carry the C and B bits stored with the matching entry.
- R5: The 2-bit permission field decides faults as follows:
  - 00: every access faults.
  - 01: any user access faults.
  - 10: a user write faults.
  - 11: nothing faults.
- R6: When an entry's supervisor-only flag is 1, any user access to it faults, whatever its permission field says.
- R7: `lk_miss` is 1 whenever no valid entry matches, which includes every lookup after reset.
- R8: When several valid entries match, the lowest-numbered entry supplies the result.
- R9: A refill is written into the lowest-numbered invalid entry. The tag and base are stored with the bits below the page boundary cleared.
- R10: When all entries are valid, a refill replaces the entry named by a round-robin victim pointer. The pointer starts at 0 after reset and advances by one on each such replacement.
- R11: A flush clears every valid bit, so all lookups miss from the next cycle on.
- R12: A refill asserted in the same cycle as a flush writes nothing.
- R13: `lk_hit` is 1 only when an entry matches and no permission fault is raised. `lk_fault` is 1 only when an entry matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_user | input | 1 | 1 = user access, 0 = privileged |
| lk_write | input | 1 | 1 = write, 0 = read |
| lk_miss | output | 1 | No valid entry matches |
| lk_hit | output | 1 | Match with access allowed |
| lk_fault | output | 1 | Match with access denied |
| lk_paddr | output | 32 | Translated physical address |
| lk_cacheable | output | 1 | C attribute of the matching entry |
| lk_bufferable | output | 1 | B attribute of the matching entry |
| fill_en | input | 1 | Write one entry this cycle |
| fill_vaddr | input | 32 | Virtual address of the new mapping |
| fill_paddr | input | 32 | Physical base of the new mapping |
| fill_size | input | 2 | 00 section, 01 large, 10 small |
| fill_c | input | 1 | Cacheable attribute |
| fill_b | input | 1 | Bufferable attribute |
| fill_perm | input | 2 | Permission code |
| fill_sup | input | 1 | Supervisor-only flag |
| flush | input | 1 | Invalidate all entries |

## Verification
The hardest situation to reach from the ports is round-robin replacement. It only happens once every slot is valid. Its effect shows only through which older mapping disappears. The stimulus therefore fills all eight slots with distinct mappings. It then issues further refills and looks up both the evicted mappings and the survivors.

Overlap priority needs similar care. A small page is placed inside a section that was loaded earlier, so both entries match the same address. The lookup result must show the lower slot's base. The same region is checked again after that slot has been evicted.

// File: rtl/xtlb_pkg.sv
package xtlb_pkg;

    localparam int VA_W = 32;

    typedef logic [VA_W-1:0] addr_t;

    typedef enum logic [1:0] {
        PG_SECTION = 2'b00,
        PG_LARGE   = 2'b01,
        PG_SMALL   = 2'b10,
        PG_RSVD    = 2'b11
    } pg_size_e;

    typedef enum logic [1:0] {
        AP_NONE    = 2'b00,
        AP_PRIV    = 2'b01,
        AP_USER_RO = 2'b10,
        AP_FULL    = 2'b11
    } ap_e;

    typedef struct packed {
        logic     valid;
        pg_size_e size;
        addr_t    tag;
        addr_t    base;
        logic     c;
        logic     b;
        ap_e      ap;
        logic     sup;
    } tlb_ent_t;

    typedef struct packed {
        addr_t    va;
        addr_t    pa;
        pg_size_e size;
        logic     c;
        logic     b;
        ap_e      ap;
        logic     sup;
    } fill_req_t;

    typedef struct packed {
        logic  any;
        logic  deny;
        addr_t pa;
        logic  c;
        logic  b;
    } lk_rsp_t;

    // Bits that take part in the tag compare for each region size.
    function automatic addr_t cmp_mask(pg_size_e s);
        case (s)
            PG_SECTION: return 32'hFFF0_0000;
            PG_LARGE:   return 32'hFFFF_0000;
            default:    return 32'hFFFF_F000;
        endcase
    endfunction

    function automatic logic perm_denied(ap_e ap, logic sup_only,
                                         logic user, logic write);
        if (!user)
            return (ap == AP_NONE);
        if (sup_only)
            return 1'b1;
        case (ap)
            AP_NONE, AP_PRIV: return 1'b1;
            AP_USER_RO:       return write;
            default:          return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/xtlb_match.sv
module xtlb_match
    import xtlb_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  tlb_ent_t [ENTRIES-1:0] ents,
    input  addr_t                  vaddr,
    output logic     [ENTRIES-1:0] hit_vec
);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit_vec[g] = ents[g].valid &&
                            ((vaddr & cmp_mask(ents[g].size)) == ents[g].tag);
    end

endmodule

// File: rtl/xtlb_prio.sv
module xtlb_prio #(
    parameter int ENTRIES = 8,
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ENTRIES-1:0] hit_vec,
    output logic [ENTRIES-1:0] grant,
    output logic [IDX_W-1:0]   idx,
    output logic               any
);

    always_comb begin
        idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i])
                idx = IDX_W'(i);
        end
        any   = |hit_vec;
        grant = '0;
        if (any)
            grant[idx] = 1'b1;
    end

endmodule

// File: rtl/xtlb_victim.sv
module xtlb_victim #(
    parameter int ENTRIES = 8,
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ENTRIES-1:0] valid_vec,
    input  logic               take,
    output logic [IDX_W-1:0]   slot
);

    logic [IDX_W-1:0] rr_q;
    logic [IDX_W-1:0] free_idx;
    logic             full;

    always_comb begin
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_vec[i])
                free_idx = IDX_W'(i);
        end
        full = &valid_vec;
        slot = full ? rr_q : free_idx;
    end

    always_ff @(posedge clk) begin
        if (rst)
            rr_q <= '0;
        else if (take && full)
            rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end

endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
    import xtlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] lk_vaddr,
    input  logic        lk_user,
    input  logic        lk_write,
    output logic        lk_miss,
    output logic        lk_hit,
    output logic        lk_fault,
    output logic [31:0] lk_paddr,
    output logic        lk_cacheable,
    output logic        lk_bufferable,
    input  logic        fill_en,
    input  logic [31:0] fill_vaddr,
    input  logic [31:0] fill_paddr,
    input  logic [1:0]  fill_size,
    input  logic        fill_c,
    input  logic        fill_b,
    input  logic [1:0]  fill_perm,
    input  logic        fill_sup,
    input  logic        flush
);

    tlb_ent_t [ENTRIES-1:0] ents;
    logic     [ENTRIES-1:0] valid_vec;
    logic     [ENTRIES-1:0] hit_vec;
    logic     [ENTRIES-1:0] grant;
    logic     [IDX_W-1:0]   hit_idx;
    logic     [IDX_W-1:0]   fill_slot;
    logic                   hit_any;
    logic                   fill_go;
    fill_req_t              freq;
    tlb_ent_t               new_ent;
    tlb_ent_t               sel;
    lk_rsp_t                rsp;

    // Refill request, normalised to page boundaries.
    always_comb begin
        freq.va   = fill_vaddr;
        freq.pa   = fill_paddr;
        freq.size = pg_size_e'(fill_size);
        freq.c    = fill_c;
        freq.b    = fill_b;
        freq.ap   = ap_e'(fill_perm);
        freq.sup  = fill_sup;

        new_ent.valid = 1'b1;
        new_ent.size  = freq.size;
        new_ent.tag   = freq.va & cmp_mask(freq.size);
        new_ent.base  = freq.pa & cmp_mask(freq.size);
        new_ent.c     = freq.c;
        new_ent.b     = freq.b;
        new_ent.ap    = freq.ap;
        new_ent.sup   = freq.sup;
    end

    assign fill_go = fill_en && !flush;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        assign valid_vec[g] = ents[g].valid;

        always_ff @(posedge clk) begin
            if (rst)
                ents[g] <= '0;
            else if (flush)
                ents[g].valid <= 1'b0;
            else if (fill_go && fill_slot == IDX_W'(g))
                ents[g] <= new_ent;
        end
    end

    xtlb_victim #(.ENTRIES(ENTRIES)) u_victim (
        .clk       (clk),
        .rst       (rst),
        .valid_vec (valid_vec),
        .take      (fill_go),
        .slot      (fill_slot)
    );

    xtlb_match #(.ENTRIES(ENTRIES)) u_match (
        .ents    (ents),
        .vaddr   (lk_vaddr),
        .hit_vec (hit_vec)
    );

    xtlb_prio #(.ENTRIES(ENTRIES)) u_prio (
        .hit_vec (hit_vec),
        .grant   (grant),
        .idx     (hit_idx),
        .any     (hit_any)
    );

    always_comb begin
        sel      = ents[hit_idx];
        rsp.any  = hit_any;
        rsp.deny = hit_any && perm_denied(sel.ap, sel.sup, lk_user, lk_write);
        rsp.pa   = sel.base | (lk_vaddr & ~cmp_mask(sel.size));
        rsp.c    = sel.c;
        rsp.b    = sel.b;
    end

    assign lk_miss       = !rsp.any;
    assign lk_fault      = rsp.deny;
    assign lk_hit        = rsp.any && !rsp.deny;
    assign lk_paddr      = rsp.pa;
    assign lk_cacheable  = rsp.c;
    assign lk_bufferable = rsp.b;

endmodule

module xtlb_chk #(
    parameter int ENTRIES = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               flush,
    input logic               fill_en,
    input logic [31:0]        lk_vaddr,
    input logic [31:0]        lk_paddr,
    input logic               lk_miss,
    input logic               lk_hit,
    input logic               lk_fault,
    input logic [ENTRIES-1:0] valid_vec,
    input logic [ENTRIES-1:0] grant
);

    p_hit_exclusive_r13: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> (!lk_miss && !lk_fault));

    p_fault_needs_match_r13: assert property (@(posedge clk) disable iff (rst)
        lk_fault |-> !lk_miss);

    p_offset_passes_r3: assert property (@(posedge clk) disable iff (rst)
        !lk_miss |-> (lk_paddr[11:0] == lk_vaddr[11:0]));

    p_single_winner_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    p_flush_empties_r11: assert property (@(posedge clk) disable iff (rst)
        flush |=> (lk_miss && valid_vec == '0));

    p_flush_beats_fill_r12: assert property (@(posedge clk) disable iff (rst)
        (flush && fill_en) |=> (valid_vec == '0));

    p_valid_only_grows_r9: assert property (@(posedge clk) disable iff (rst)
        !flush |=> ($countones(valid_vec) >= $past($countones(valid_vec))));

endmodule

bind xlat_tlb xtlb_chk #(.ENTRIES(ENTRIES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush),
    .fill_en   (fill_en),
    .lk_vaddr  (lk_vaddr),
    .lk_paddr  (lk_paddr),
    .lk_miss   (lk_miss),
    .lk_hit    (lk_hit),
    .lk_fault  (lk_fault),
    .valid_vec (valid_vec),
    .grant     (grant)
);

// File: tb/xlat_tlb_bench.sv
module xlat_tlb_bench;

    localparam logic [1:0] FL = 2'd0;   // refill
    localparam logic [1:0] LK = 2'd1;   // lookup
    localparam logic [1:0] FF = 2'd3;   // flush and refill together

    typedef struct packed {
        logic [1:0]  op;
        logic [31:0] va;
        logic [31:0] pa;
        logic [1:0]  sz;
        logic        c;
        logic        b;
        logic [1:0]  ap;
        logic        sup;
        logic        wr;
        logic        usr;
        logic        emiss;
        logic        efault;
        logic [31:0] epa;
        logic        ec;
        logic        eb;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 36;
    // op, va, pa, sz, c, b, ap, sup, wr, usr, emiss, efault, epa, ec, eb, req
    localparam vec_t VT [NV] = '{
        '{LK, 32'h12345678, 32'h0, 2'd0, 0, 0, 2'd0, 0, 0, 1, 1, 0, 32'h0, 0, 0, 8'd7},          // R7 empty
        '{FL, 32'h123FFFFF, 32'hABCFFFFF, 2'd0, 1, 0, 2'd3, 0, 0, 0, 0, 0, 32'h0, 0, 0, 8'd9},   // slot0 section
        '{LK, 32'h12345678, 32'h0, 2'd0, 0, 0, 2'd0, 0, 0, 1, 0, 0, 32'hABC45678, 1, 0, 8'd1},   // R1
        '{LK, 32'h12400000, 32'h0, 2'd0, 0, 0, 2'd0, 0, 0, 1, 1, 0, 32'h0, 0, 0, 8'd1},          // R1 outside
        '{FL, 32'h40010000, 32'h7F230000, 2'd1, 0, 1, 2'd2, 0, 0, 0, 0, 0, 32'h0, 0, 0, 8'd9},   // slot1 large
        '{LK, 32'h4001BEEF, 32'h0, 2'd0, 0, 0, 2'd0, 0, 0, 1, 0, 0, 32'h7F23BEEF, 0, 1, 8'd2},   // R2 / R4
        '{LK, 32'h4002BEEF, 32'h0, 2'd0, 0, 0, 2'd0, 0, 0, 1, 1, 0, 32'h0, 0, 0, 8'd2},          // R2 outside
        '{LK, 32'h4001BEEF, 32'h0, 2'd0, 0, 0, 2'd0, 0, 1, 1, 0, 1, 32'h0, 0, 0, 8'd5},          // R5 user write on 10
        '{LK, 32'h4001BEEF, 32'h0, 2'd0, 0, 0, 2'd0, 0, 1, 0, 0, 0, 32'h7F23BEEF, 0, 1, 8'd5},   // R5 priv write
        '{FL, 32'h00007000, 32'h55555000, 2'd2, 1, 1, 2'd1, 0, 0, 0, 0, 0, 32'h0, 0, 0, 8'd9},   // slot2 small
        '{LK, 32'h00007ABC, 32'h0, 2'd0, 0, 0, 2'd0, 0, 0, 1, 0, 1, 32'h0, 0, 0, 8'd5},          // R5 user on 01
        '{LK, 32'h00007ABC, 32'h0, 2'd0, 0, 0, 2'd0, 0, 1, 0, 0, 0, 32'h55555ABC, 1, 1, 8'd3},   // R3
        '{LK, 32'h00008ABC, 32'h0, 2'd0, 0, 0, 2'd0, 0, 0, 0, 1, 0, 32'h0, 0, 0, 8'd3},          // R3 outside
        '{FL, 32'h00009000, 32'h10000000, 2'd2, 0, 0, 2'd0, 0, 0, 0, 0, 0, 32'h0, 0, 0, 8'd9},   // slot3 no access
        '{LK, 32'h00009004, 32'h0, 2'd0, 0, 0, 2'd0, 0, 0, 0, 0, 1, 32'h0, 0, 0, 8'd5},          // R5 priv on 00
        '{FL, 32'h0000A000, 32'h2000A000, 2'd2, 0, 0, 2'd3, 1, 0, 0, 0, 0, 32'h0, 0, 0, 8'd9},   // slot4 sup only
        '{LK, 32'h0000A010, 32'h0, 2'd0, 0, 0, 2'd0, 0, 0, 1, 0, 1, 32'h0, 0, 0, 8'd6},          // R6 user
        '{LK, 32'h0000A010, 32'h0, 2'd0, 0, 0, 2'd0, 0, 1, 0, 0, 0, 32'h2000A010, 0, 0, 8'd6},   // R6 priv
        '{FL, 32'h12300000, 32'h99999000, 2'd2, 0, 1, 2'd3, 0, 0, 0, 0, 0, 32'h0, 0, 0, 8'd9},   // slot5 overlaps slot0
        '{LK, 32'h12300123, 32'h0, 2'd0, 0, 0, 2'd0, 0, 0, 0, 0, 0, 32'hABC00123, 1, 0, 8'd8},   // R8
        '{FL, 32'h0000B000, 32'h3000B000, 2'd2, 0, 0, 2'd3, 0, 0, 0, 0, 0, 32'h0, 0, 0, 8'd9},   // slot6
        '{FL, 32'h0000C000, 32'h3000C000, 2'd2, 0, 0, 2'd3, 0, 0, 0, 0, 0, 32'h0, 0, 0, 8'd9},   // slot7
        '{LK, 32'h0000C008, 32'h0, 2'd0, 0, 0, 2'd0, 0, 0, 0, 0, 0, 32'h3000C008, 0, 0, 8'd9},   // R9 last slot
        '{FL, 32'h0000D000, 32'h3000D000, 2'd2, 0, 0, 2'd3, 0, 0, 0, 0, 0, 32'h0, 0, 0, 8'd10},  // evicts slot0
        '{LK, 32'h12345678, 32'h0, 2'd0, 0, 0, 2'd0, 0, 0, 0, 1, 0, 32'h0, 0, 0, 8'd10},         // R10 gone
        '{LK, 32'h12300123, 32'h0, 2'd0, 0, 0, 2'd0, 0, 0, 0, 0, 0, 32'h99999123, 0, 1, 8'd10},  // R10 slot5 now
        '{LK, 32'h4001BEEF, 32'h0, 2'd0, 0, 0, 2'd0, 0, 0, 0, 0, 0, 32'h7F23BEEF, 0, 1, 8'd10},  // R10 slot1 kept
        '{FL, 32'h0000E000, 32'h3000E000, 2'd2, 0, 0, 2'd3, 0, 0, 0, 0, 0, 32'h0, 0, 0, 8'd10},  // evicts slot1
        '{LK, 32'h4001BEEF, 32'h0, 2'd0, 0, 0, 2'd0, 0, 0, 0, 1, 0, 32'h0, 0, 0, 8'd10},         // R10 gone
        '{LK, 32'h0000D004, 32'h0, 2'd0, 0, 0, 2'd0, 0, 0, 0, 0, 0, 32'h3000D004, 0, 0, 8'd10},  // R10 new
        '{FF, 32'h0000F000, 32'h3000F000, 2'd2, 0, 0, 2'd3, 0, 0, 0, 0, 0, 32'h0, 0, 0, 8'd12},  // flush + fill
        '{LK, 32'h0000F000, 32'h0, 2'd0, 0, 0, 2'd0, 0, 0, 0, 1, 0, 32'h0, 0, 0, 8'd12},         // R12
        '{LK, 32'h0000D004, 32'h0, 2'd0, 0, 0, 2'd0, 0, 0, 0, 1, 0, 32'h0, 0, 0, 8'd11},         // R11
        '{LK, 32'h00007ABC, 32'h0, 2'd0, 0, 0, 2'd0, 0, 0, 0, 1, 0, 32'h0, 0, 0, 8'd11},         // R11
        '{FL, 32'h00000000, 32'h60000000, 2'd0, 1, 1, 2'd3, 0, 0, 0, 0, 0, 32'h0, 0, 0, 8'd9},   // refill after flush
        '{LK, 32'h00007ABC, 32'h0, 2'd0, 0, 0, 2'd0, 0, 0, 0, 0, 0, 32'h60007ABC, 1, 1, 8'd9}    // R9 / R4
    };

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] lk_vaddr;
    logic        lk_user;
    logic        lk_write;
    logic        lk_miss;
    logic        lk_hit;
    logic        lk_fault;
    logic [31:0] lk_paddr;
    logic        lk_cacheable;
    logic        lk_bufferable;
    logic        fill_en;
    logic [31:0] fill_vaddr;
    logic [31:0] fill_paddr;
    logic [1:0]  fill_size;
    logic        fill_c;
    logic        fill_b;
    logic [1:0]  fill_perm;
    logic        fill_sup;
    logic        flush;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    xlat_tlb u_xlat_tlb (
        .clk           (clk),
        .rst           (rst),
        .lk_vaddr      (lk_vaddr),
        .lk_user       (lk_user),
        .lk_write      (lk_write),
        .lk_miss       (lk_miss),
        .lk_hit        (lk_hit),
        .lk_fault      (lk_fault),
        .lk_paddr      (lk_paddr),
        .lk_cacheable  (lk_cacheable),
        .lk_bufferable (lk_bufferable),
        .fill_en       (fill_en),
        .fill_vaddr    (fill_vaddr),
        .fill_paddr    (fill_paddr),
        .fill_size     (fill_size),
        .fill_c        (fill_c),
        .fill_b        (fill_b),
        .fill_perm     (fill_perm),
        .fill_sup      (fill_sup),
        .flush         (flush)
    );

    task automatic do_fill(input vec_t v, input logic with_flush);
        @(negedge clk);
        fill_en    = 1'b1;
        flush      = with_flush;
        fill_vaddr = v.va;
        fill_paddr = v.pa;
        fill_size  = v.sz;
        fill_c     = v.c;
        fill_b     = v.b;
        fill_perm  = v.ap;
        fill_sup   = v.sup;
        @(negedge clk);
        fill_en = 1'b0;
        flush   = 1'b0;
    endtask

    task automatic do_look(input vec_t v);
        logic ok;
        @(negedge clk);
        lk_vaddr = v.va;
        lk_user  = v.usr;
        lk_write = v.wr;
        #1;
        checks++;
        if (v.emiss)
            ok = (lk_miss === 1'b1) && (lk_hit === 1'b0) && (lk_fault === 1'b0);
        else if (v.efault)
            ok = (lk_miss === 1'b0) && (lk_hit === 1'b0) && (lk_fault === 1'b1);
        else
            ok = (lk_miss === 1'b0) && (lk_hit === 1'b1) && (lk_fault === 1'b0) &&
                 (lk_paddr === v.epa) && (lk_cacheable === v.ec) &&
                 (lk_bufferable === v.eb);
        if (!ok) begin
            errors++;
            $display("FAIL R%0d va=%h: got miss=%b hit=%b fault=%b pa=%h c=%b b=%b, expected miss=%b fault=%b pa=%h c=%b b=%b",
                     v.req, v.va, lk_miss, lk_hit, lk_fault, lk_paddr, lk_cacheable,
                     lk_bufferable, v.emiss, v.efault, v.epa, v.ec, v.eb);
        end
    endtask

    initial begin
        rst        = 1'b1;
        lk_vaddr   = '0;
        lk_user    = 1'b0;
        lk_write   = 1'b0;
        fill_en    = 1'b0;
        fill_vaddr = '0;
        fill_paddr = '0;
        fill_size  = '0;
        fill_c     = 1'b0;
        fill_b     = 1'b0;
        fill_perm  = '0;
        fill_sup   = 1'b0;
        flush      = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            case (VT[i].op)
                FL:      do_fill(VT[i], 1'b0);
                FF:      do_fill(VT[i], 1'b1);
                default: do_look(VT[i]);
            endcase
        end

        // R7: a mid-run reset drops the mapping loaded after the flush.
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        do_look('{LK, 32'h00007ABC, 32'h0, 2'd0, 0, 0, 2'd0, 0, 0, 0, 1, 0, 32'h0, 0, 0, 8'd7});

        // R9: after reset the first refill lands in slot 0 and translates.
        do_fill('{FL, 32'hFFFF0000, 32'h0ABC0000, 2'd1, 1, 0, 2'd3, 0, 0, 0, 0, 0, 32'h0, 0, 0, 8'd9}, 1'b0);
        do_look('{LK, 32'hFFFF1234, 32'h0, 2'd0, 0, 0, 2'd0, 0, 1, 1, 0, 0, 32'h0ABC1234, 1, 0, 8'd9});

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule